// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block handles the status-register side of taking and leaving exceptions. Each cycle it looks at the exception request lines, the instruction-complete strobe, the current program counter and the current status word. When it accepts an exception, it saves the incoming status word in a saved-status register that belongs to the target mode. It saves the incoming PC in that mode's link register. It then presents a new status word and the vector address on its outputs, with a one-cycle `redirect` strobe.

A return command restores the status word from the saved-status register of the current mode and the PC from that mode's link register. It uses the same one-cycle strobe. The surrounding datapath loads `pc_out` and `psr_out` whenever `redirect` is high. All five saved-status and link banks are visible on flat output buses.

Status word layout: bit 31 N, bit 30 Z, bit 29 C, bit 28 V, bit 7 normal-interrupt disable (I), bit 6 fast-interrupt disable (F), bit 5 state bit (T, 0 = 32-bit instruction state), bits 4:0 mode. Mode codes: user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `redirect` is 0, `pc_out` is 0, `psr_out` is 0x000000D3 (supervisor, I and F set), and every bank entry is 0.
- R2: On entry, the incoming status word is written to the saved-status bank of the target mode and `pc_in` is written to that mode's link bank. The bank index order on the flat buses is: 0 fast interrupt, 1 normal interrupt, 2 supervisor, 3 abort, 4 undefined. Entry n occupies bits [32n+31:32n].
- R3: On entry, `psr_out` keeps N, Z, C, V and bits 27:8 of `psr_in`, clears T, sets I and carries the target mode. The mode is supervisor for reset and software interrupt, abort for both aborts, undefined for undefined instruction, and the matching interrupt mode for the two interrupts. `redirect` is high for exactly that one result.
- R4: F is set on entry to reset and to fast interrupt. For every other exception, F is copied from `psr_in`.
- R5: `pc_out` on entry is the vector offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R6: A reset request is taken regardless of `insn_done`. Every other exception is taken only in a cycle with `insn_done` high.
- R7: When several requests are accepted together, the winner is, from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R8: A normal-interrupt request is ignored while `psr_in` bit 7 is 1. A fast-interrupt request is ignored while `psr_in` bit 6 is 1.
- R9: A return command with T = 0 in a banked mode drives `psr_out` to that mode's saved status and `pc_out` to its link value, with `redirect` high.
- R10: A return command is ignored when T = 1, when the mode is user or system, or when an exception is taken in the same cycle. An ignored return produces no `redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Reset exception request |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| pabt_req | input | 1 | Prefetch abort request |
| dabt_req | input | 1 | Data abort request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| insn_done | input | 1 | Current instruction has completed |
| ret_req | input | 1 | Exception return command |
| pc_in | input | AW | Current PC, saved as return address |
| psr_in | input | 32 | Current status word |
| redirect | output | 1 | New PC and status word valid this cycle |
| pc_out | output | AW | New PC |
| psr_out | output | 32 | New status word |
| spsr_bank | output | 160 | Saved-status banks, five entries |
| lr_bank | output | 5*AW | Link banks, five entries |

## Verification
Every result is registered once. The outputs and the banks therefore change on the first rising edge after the inputs that caused them, and `redirect` drops again one edge later. The driver applies each stimulus on a falling edge and queues the expected item at that moment. The monitor pops it 5 ns after the next rising edge, so every comparison lands in the cycle where the result first appears. The driver also queues an item for every idle or ignored stimulus, which holds the one-cycle pulse length and the no-effect cases to the same timing.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int AW = 32,
  parameter logic [31:0] RST_PSR = 32'h0000_00D3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic            und_req,
  input  logic            swi_req,
  input  logic            pabt_req,
  input  logic            dabt_req,
  input  logic            irq_req,
  input  logic            fiq_req,
  input  logic            insn_done,
  input  logic            ret_req,
  input  logic [AW-1:0]   pc_in,
  input  logic [31:0]     psr_in,
  output logic            redirect,
  output logic [AW-1:0]   pc_out,
  output logic [31:0]     psr_out,
  output logic [159:0]    spsr_bank,
  output logic [5*AW-1:0] lr_bank
);
  localparam int NB = 5;
  localparam logic [2:0] NOBANK = 3'd7;

  localparam logic [2:0] S_RST = 3'd0, S_UND = 3'd1, S_SWI = 3'd2, S_PABT = 3'd3,
                         S_DABT = 3'd4, S_IRQ = 3'd6, S_FIQ = 3'd7;

  function automatic logic [4:0] mode_of(input logic [2:0] s);
    case (s)
      S_FIQ:          mode_of = 5'b10001;
      S_IRQ:          mode_of = 5'b10010;
      S_PABT, S_DABT: mode_of = 5'b10111;
      S_UND:          mode_of = 5'b11011;
      default:        mode_of = 5'b10011;
    endcase
  endfunction

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: bank_of = 3'd0;
      5'b10010: bank_of = 3'd1;
      5'b10011: bank_of = 3'd2;
      5'b10111: bank_of = 3'd3;
      5'b11011: bank_of = 3'd4;
      default:  bank_of = NOBANK;
    endcase
  endfunction

  logic       take;
  logic [2:0] slot;
  wire irq_ok = irq_req & ~psr_in[7];
  wire fiq_ok = fiq_req & ~psr_in[6];

  always_comb begin
    take = 1'b1;
    slot = S_RST;
    if (rst_req)        slot = S_RST;
    else if (!insn_done) take = 1'b0;
    else if (dabt_req)  slot = S_DABT;
    else if (fiq_ok)    slot = S_FIQ;
    else if (irq_ok)    slot = S_IRQ;
    else if (pabt_req)  slot = S_PABT;
    else if (und_req)   slot = S_UND;
    else if (swi_req)   slot = S_SWI;
    else                take = 1'b0;
  end

  wire [4:0] tgt_mode = mode_of(slot);
  wire [2:0] tgt_bank = bank_of(tgt_mode);
  wire [2:0] cur_bank = bank_of(psr_in[4:0]);
  wire       ret_ok   = ret_req & ~psr_in[5] & (cur_bank != NOBANK) & ~take;
  wire       f_force  = (slot == S_RST) || (slot == S_FIQ);

  wire [31:0] entry_psr = {psr_in[31:8], 1'b1, f_force | psr_in[6], 1'b0, tgt_mode};

  logic [31:0]   spsr_q [NB];
  logic [AW-1:0] lr_q   [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spsr_q[i] <= '0;
        lr_q[i]   <= '0;
      end else if (take && tgt_bank == 3'(i)) begin
        spsr_q[i] <= psr_in;
        lr_q[i]   <= pc_in;
      end
    end
    assign spsr_bank[32*i +: 32] = spsr_q[i];
    assign lr_bank[AW*i +: AW]   = lr_q[i];
  end

  logic [31:0]   ret_psr;
  logic [AW-1:0] ret_pc;
  always_comb begin
    ret_psr = '0;
    ret_pc  = '0;
    for (int i = 0; i < NB; i++)
      if (cur_bank == 3'(i)) begin
        ret_psr = spsr_q[i];
        ret_pc  = lr_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect <= 1'b0;
      pc_out   <= '0;
      psr_out  <= RST_PSR;
    end else begin
      redirect <= take | ret_ok;
      if (take) begin
        pc_out  <= AW'({slot, 2'b00});
        psr_out <= entry_psr;
      end else if (ret_ok) begin
        pc_out  <= ret_pc;
        psr_out <= ret_psr;
      end
    end
  end

  assert_entry_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redirect && !psr_out[5] && psr_out[7]);

  assert_fast_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (slot == S_RST || slot == S_FIQ)) |=> psr_out[6]);

  assert_vector_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_out[1:0] == 2'b00) && (pc_out[AW-1:5] == '0) && (pc_out[4:2] != 3'd5));

  assert_reset_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> redirect && pc_out == '0 && psr_out[4:0] == 5'b10011);

  assert_wait_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !insn_done && !ret_req) |=> !redirect);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == S_IRQ) |-> !psr_in[7]);

  assert_fiq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot == S_FIQ) |-> !psr_in[6]);

  assert_ret_thumb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && psr_in[5] && !rst_req && !insn_done) |=> !redirect);
endmodule

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rst_req, und_req, swi_req, pabt_req, dabt_req, irq_req, fiq_req, insn_done, ret_req;
  logic [AW-1:0] pc_in;
  logic [31:0] psr_in;
  logic redirect;
  logic [AW-1:0] pc_out;
  logic [31:0] psr_out;
  logic [159:0] spsr_bank;
  logic [5*AW-1:0] lr_bank;

  exc_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .und_req(und_req), .swi_req(swi_req),
    .pabt_req(pabt_req), .dabt_req(dabt_req), .irq_req(irq_req), .fiq_req(fiq_req),
    .insn_done(insn_done), .ret_req(ret_req), .pc_in(pc_in), .psr_in(psr_in),
    .redirect(redirect), .pc_out(pc_out), .psr_out(psr_out),
    .spsr_bank(spsr_bank), .lr_bank(lr_bank));

  typedef struct {
    logic rd; logic [31:0] pc; logic [31:0] psr;
    int bank; logic [31:0] sp; logic [31:0] lr; string tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  logic [31:0] m_sp [5];
  logic [31:0] m_lr [5];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic drive(input logic r, u, s, pa, da, ir, fi, dn, rt,
                       input logic [31:0] pc, psr, input string tag);
    item_t it;
    int slot, b;
    logic [4:0] m;
    @(negedge clk);
    rst_req = r; und_req = u; swi_req = s; pabt_req = pa; dabt_req = da;
    irq_req = ir; fiq_req = fi; insn_done = dn; ret_req = rt; pc_in = pc; psr_in = psr;
    slot = -1;
    if (r) slot = 0;
    else if (dn) begin
      if (da) slot = 4;
      else if (fi && !psr[6]) slot = 7;
      else if (ir && !psr[7]) slot = 6;
      else if (pa) slot = 3;
      else if (u) slot = 1;
      else if (s) slot = 2;
    end
    it.tag = tag; it.bank = -1; it.rd = 1'b0; it.pc = '0; it.psr = '0; it.sp = '0; it.lr = '0;
    if (slot >= 0) begin
      case (slot)
        7: m = 5'b10001;
        6: m = 5'b10010;
        3, 4: m = 5'b10111;
        1: m = 5'b11011;
        default: m = 5'b10011;
      endcase
      b = bidx(m);
      m_sp[b] = psr; m_lr[b] = pc;
      it.rd = 1'b1; it.pc = 32'(slot * 4);
      it.psr = {psr[31:8], 1'b1, (slot == 0 || slot == 7) ? 1'b1 : psr[6], 1'b0, m};
      it.bank = b; it.sp = psr; it.lr = pc;
    end else if (rt && !psr[5] && bidx(psr[4:0]) >= 0) begin
      b = bidx(psr[4:0]);
      it.rd = 1'b1; it.pc = m_lr[b]; it.psr = m_sp[b];
    end
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    drive(0,0,0,0,0,0,0,0,0, 32'h0, 32'h10, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.tag, " redirect"}, {31'b0, redirect}, {31'b0, it.rd});
      if (it.rd) begin
        chk({it.tag, " pc"}, pc_out, it.pc);
        chk({it.tag, " psr"}, psr_out, it.psr);
      end
      if (it.bank >= 0) begin
        chk({it.tag, " saved-status bank"}, spsr_bank[32*it.bank +: 32], it.sp);
        chk({it.tag, " link bank"}, lr_bank[AW*it.bank +: AW], it.lr);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
    rst_n = 1'b0; rst_req = 0; und_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
    irq_req = 0; fiq_req = 0; insn_done = 0; ret_req = 0; pc_in = '0; psr_in = 32'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 pc", pc_out, 32'h0);
    chk("R1 psr", psr_out, 32'h0000_00D3);
    chk("R1 spsr banks", spsr_bank[31:0] | spsr_bank[63:32] | spsr_bank[95:64] | spsr_bank[127:96] | spsr_bank[159:128], 32'h0);
    chk("R1 lr banks", lr_bank[31:0] | lr_bank[63:32] | lr_bank[95:64] | lr_bank[127:96] | lr_bank[159:128], 32'h0);

    drive(0,0,1,0,0,0,0,1,0, 32'h0000_1000, 32'hF000_0010, "R2 R3 R5 swi entry");
    idle("R3 pulse ends");
    drive(0,0,1,0,0,0,0,0,0, 32'h0000_2000, 32'h0000_0010, "R6 swi without done");
    drive(0,0,0,0,0,1,0,1,0, 32'h0000_3000, 32'hA000_0050, "R4 R5 irq entry keeps F");
    drive(0,0,0,0,0,1,0,1,0, 32'h0000_3004, 32'h0000_0090, "R8 irq masked");
    drive(0,0,0,0,0,0,1,1,0, 32'h0000_3008, 32'h0000_0050, "R8 fiq masked");
    drive(0,0,0,0,0,0,1,1,0, 32'h0000_4000, 32'h5000_0010, "R4 R5 fiq entry");
    drive(0,0,0,0,1,0,1,1,0, 32'h0000_5000, 32'h0000_0010, "R7 dabt over fiq");
    drive(0,1,0,1,0,0,0,1,0, 32'h0000_6000, 32'h0000_0010, "R7 pabt over und");
    drive(0,1,1,0,0,0,0,1,0, 32'h0000_7000, 32'h3000_0010, "R7 und over swi");
    drive(0,0,0,0,0,1,1,1,0, 32'h0000_7800, 32'h0000_0010, "R7 fiq over irq");
    drive(1,1,1,1,1,1,1,1,1, 32'h0000_8000, 32'h8000_0012, "R7 reset over all");
    drive(1,0,0,0,0,0,0,0,0, 32'h0000_9000, 32'h0000_0010, "R6 reset without done");
    drive(0,0,1,0,0,0,0,1,0, 32'h0000_A000, 32'hC000_001F, "R2 swi from system");
    drive(0,0,0,0,0,0,0,0,1, 32'h0000_0008, 32'h0000_0093, "R9 return from svc");
    drive(0,0,0,0,0,0,0,0,1, 32'h0000_001C, 32'h0000_00D1, "R9 return from fiq");
    drive(0,0,0,0,0,0,0,0,1, 32'h0000_0018, 32'h0000_00B7, "R10 return in thumb");
    drive(0,0,0,0,0,0,0,0,1, 32'h0000_0000, 32'h0000_0010, "R10 return in user");
    drive(0,0,0,0,0,1,0,1,1, 32'h0000_B000, 32'h0000_0012, "R10 irq beats return");
    drive(0,0,0,0,0,0,0,0,1, 32'h0000_0018, 32'h0000_0092, "R9 return from irq");
    idle("idle 1");
    idle("idle 2");
    @(negedge clk);
    finish_run();
  end
endmodule